// File: doc/BRIEF.md
# Byte-per-pixel VGA scanout engine with multiplexed SRAM address

This block produces the horizontal and vertical sync timing for a 640x480, 60 Hz raster and sequences an external byte-wide SRAM. During active video the SRAM data bus feeds a colour DAC directly, so the block never touches pixel data on the display path. The colour byte carries red in three bits, green in three bits and blue in two bits, which makes 256 colours. The block only supplies addresses, and a new address appears every two clocks. The picture is 320x240: each pixel lasts two dot clocks and each stored row is shown on two consecutive raster lines.

The 19-bit SRAM address leaves the block in pieces. Bits 15:8 go out on an 8-bit port into an external transparent latch, which closes while bits 7:0 are driven on the same port. Bit 16 and bits 18:17 have their own pins. The latch cannot be reloaded within a two-clock pixel, so a row never crosses into the next 256-byte page. Pixels 0..255 of a row use one page. Pixel 256 raises bit 16 on the last address of that page, and pixels 257..319 continue from the start of the page above bit 16. In each row's upper page, 192 bytes stay unused.

The DAC isolation latch is open only during active video, and the SRAM output enable follows it. Host pixel writes go into a one-entry holding register. Each write runs as a short strobe sequence inside horizontal blanking, and the block drives the data bus only while the SRAM output enable is off.

Top module: `vga_scanout`

## Requirements
- R1: While reset is asserted: hsync_n=1, vsync_n=1, dac_le=0, sram_oe_n=1, sram_we_n=1, addr_le=0, data_oe=0 and wr_ready=1.
- R2: A line is H_ACT+H_FP+H_SYNC+H_BP clocks long (default 800). Clocks are counted from position 0, which is the output state after the first rising edge with reset low. Inside a line, hsync_n is low at positions H_ACT+H_FP through H_ACT+H_FP+H_SYNC-1 (default 656..751) and high at all others.
- R3: A frame is V_ACT+V_FP+V_SYNC+V_BP lines long. vsync_n is low on lines V_ACT+V_FP through V_ACT+V_FP+V_SYNC-1 and high on all other lines.
- R4: dac_le is 1 exactly when the line position is below H_ACT and the line number is below V_ACT. sram_oe_n is its inverse at every clock.
- R5: Active position h shows pixel p=h/2, which holds for two clocks. With row r, the address is r*256+p for p<256, 65536+r*256+255 for p=256, and 65536+r*256+(p-257) for 257<=p<=319.
- R6: The full address is {addr_top[1:0], addr_b16, latched byte, addr_bus[7:0]}. The latched byte follows addr_bus while addr_le=1 and holds while addr_le=0. addr_le stays 0 throughout active video, and the latch holds the row during it.
- R7: The row is the line number divided by two, so lines 2k and 2k+1 show identical address sequences.
- R8: data_oe is never 1 while sram_oe_n is 0.
- R9: A write sequence starts only at line positions H_ACT..H_TOTAL-9. It runs for four clocks: high byte with addr_le=1, then three clocks of low byte with data_out driven and data_oe=1. sram_we_n is low for the third clock only, at a position between H_ACT+3 and H_TOTAL-6, and the full address and data_out then equal the queued request.
- R10: The request is accepted on a rising edge with wr_valid=1 and wr_ready=1. wr_ready then stays 0 until the write sequence finishes. A request accepted during active video is written at position H_ACT+3 of the same line.
- R11: Queued requests reach the SRAM in the order they were accepted, and no write disturbs the addresses shown on later active lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Holding register free |
| wr_addr | input | 19 | Host write address |
| wr_data | input | 8 | Host write byte |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| addr_bus | output | 8 | Shared address port: high byte to the latch, or low byte |
| addr_le | output | 1 | Address latch transparent when 1 |
| addr_b16 | output | 1 | SRAM address bit 16 |
| addr_top | output | 2 | SRAM address bits 18:17 |
| dac_le | output | 1 | DAC isolation latch transparent when 1 |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| data_out | output | 8 | Write data for the SRAM bus |
| data_oe | output | 1 | Block drives data_out onto the bus |

## Verification
The bench models the external latch and checks the address sequence at the page crossing, pixels 255, 256, 257 and 319. A design that increments across the page boundary, or that skips the single 65791 step, shows up at these points. It also compares the two raster lines of one row, to catch a row derived from the raw line count. A write is queued in the middle of active video to confirm that it waits for blanking and lands at the first legal slot. A sequencer that strobes too early would show a SRAM output collision, and one that forgets the latch afterwards would show a wrong row on the next line. Two writes are then queued back to back, to catch a holding register that is overwritten or a sequence that drops its second request.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  // Write sequencer phases
  typedef enum logic [2:0] {
    WP_IDLE,
    WP_HI,
    WP_LO,
    WP_STROBE,
    WP_HOLD
  } wr_phase_t;

  // Everything that leaves the block through the output register
  typedef struct packed {
    logic       hs_n;
    logic       vs_n;
    logic       vid;
    logic       we_n;
    logic       le;
    logic       b16;
    logic [1:0] top;
    logic [7:0] bus;
    logic [7:0] dout;
    logic       doe;
  } scan_drive_t;

  localparam scan_drive_t DRIVE_RESET = '{
    hs_n: 1'b1, vs_n: 1'b1, vid: 1'b0, we_n: 1'b1, le: 1'b0,
    b16: 1'b0, top: 2'b00, bus: 8'h00, dout: 8'h00, doe: 1'b0
  };

  // Pixel address of one stored row: a page of 256, then a jump via bit 16
  function automatic logic [18:0] line_pixel_addr(input logic [7:0] row,
                                                  input logic [8:0] pix);
    logic [8:0] off;
    off = pix - 9'd257;
    if (pix < 9'd256)       return {2'b00, 1'b0, row, pix[7:0]};
    else if (pix == 9'd256) return {2'b00, 1'b1, row, 8'hFF};
    else                    return {2'b00, 1'b1, row, off[7:0]};
  endfunction

endpackage

// File: rtl/vga_scan_timing.sv
module vga_scan_timing #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/vga_scan_wrq.sv
module vga_scan_wrq
  import vga_scan_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int H_TOTAL = 800,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic          wr_valid,
  input  logic [18:0]   wr_addr,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output wr_phase_t     phase,
  output logic [18:0]   q_addr,
  output logic [7:0]    q_data
);
  // a sequence started here ends before the row reload window
  localparam logic [HW-1:0] WIN_LO = HW'(H_ACT);
  localparam logic [HW-1:0] WIN_HI = HW'(H_TOTAL - 9);

  logic pend;
  logic in_win;

  assign in_win   = (hcnt >= WIN_LO) && (hcnt <= WIN_HI);
  assign wr_ready = !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      phase  <= WP_IDLE;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      if (wr_valid && !pend) begin
        pend   <= 1'b1;
        q_addr <= wr_addr;
        q_data <= wr_data;
      end
      case (phase)
        WP_IDLE:   if (pend && in_win) phase <= WP_HI;
        WP_HI:     phase <= WP_LO;
        WP_LO:     phase <= WP_STROBE;
        WP_STROBE: phase <= WP_HOLD;
        default: begin
          phase <= WP_IDLE;
          pend  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/vga_scan_mux.sv
module vga_scan_mux
  import vga_scan_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_TOTAL = 800,
  parameter int V_ACT   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_TOTAL = 525,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  wr_phase_t     phase,
  input  logic [18:0]   q_addr,
  input  logic [7:0]    q_data,
  output scan_drive_t   drive
);
  localparam logic [HW-1:0] H_ACT_C = HW'(H_ACT);
  localparam logic [HW-1:0] HS_LO   = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_HI   = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [HW-1:0] RL_LO   = HW'(H_TOTAL - 4);
  localparam logic [HW-1:0] RL_CLS  = HW'(H_TOTAL - 2);
  localparam logic [VW-1:0] V_ACT_C = VW'(V_ACT);
  localparam logic [VW-1:0] VS_LO   = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_HI   = VW'(V_ACT + V_FP + V_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);

  logic          active;
  logic          reload;
  logic [VW-1:0] vnext;
  logic [18:0]   pa;

  assign active = (hcnt < H_ACT_C) && (vcnt < V_ACT_C);
  assign reload = hcnt >= RL_LO;
  assign vnext  = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
  assign pa     = line_pixel_addr(8'(vcnt >> 1), 9'(hcnt >> 1));

  always_comb begin
    drive      = DRIVE_RESET;
    drive.hs_n = !((hcnt >= HS_LO) && (hcnt < HS_HI));
    drive.vs_n = !((vcnt >= VS_LO) && (vcnt < VS_HI));
    drive.vid  = active;
    if (active) begin
      drive.bus = pa[7:0];
      drive.b16 = pa[16];
      drive.top = pa[18:17];
    end else if (reload) begin
      // load the row of the coming line into the external latch
      drive.bus = 8'(vnext >> 1);
      drive.le  = hcnt < RL_CLS;
    end else begin
      case (phase)
        WP_HI: begin
          drive.bus = q_addr[15:8];
          drive.le  = 1'b1;
          drive.b16 = q_addr[16];
          drive.top = q_addr[18:17];
        end
        WP_LO, WP_STROBE, WP_HOLD: begin
          drive.bus  = q_addr[7:0];
          drive.b16  = q_addr[16];
          drive.top  = q_addr[18:17];
          drive.dout = q_data;
          drive.doe  = 1'b1;
          drive.we_n = (phase != WP_STROBE);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
  import vga_scan_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [18:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic [7:0]  addr_bus,
  output logic        addr_le,
  output logic        addr_b16,
  output logic [1:0]  addr_top,
  output logic        dac_le,
  output logic        sram_oe_n,
  output logic        sram_we_n,
  output logic [7:0]  data_out,
  output logic        data_oe
);
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  wr_phase_t     phase;
  logic [18:0]   q_addr;
  logic [7:0]    q_data;
  scan_drive_t   drive_d;
  scan_drive_t   drive_q;
  logic          pix_second_q;  // output shows the second clock of a pixel

  vga_scan_timing #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt)
  );

  vga_scan_wrq #(.H_ACT(H_ACT), .H_TOTAL(H_TOTAL)) u_wrq (
    .clk(clk), .rst(rst), .hcnt(hcnt),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .phase(phase), .q_addr(q_addr), .q_data(q_data)
  );

  vga_scan_mux #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_TOTAL(V_TOTAL)
  ) u_mux (
    .hcnt(hcnt), .vcnt(vcnt), .phase(phase),
    .q_addr(q_addr), .q_data(q_data), .drive(drive_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q      <= DRIVE_RESET;
      pix_second_q <= 1'b0;
    end else begin
      drive_q      <= drive_d;
      pix_second_q <= hcnt[0];
    end
  end

  assign hsync_n   = drive_q.hs_n;
  assign vsync_n   = drive_q.vs_n;
  assign addr_bus  = drive_q.bus;
  assign addr_le   = drive_q.le;
  assign addr_b16  = drive_q.b16;
  assign addr_top  = drive_q.top;
  assign dac_le    = drive_q.vid;
  assign sram_oe_n = !drive_q.vid;
  assign sram_we_n = drive_q.we_n;
  assign data_out  = drive_q.dout;
  assign data_oe   = drive_q.doe;
endmodule

// File: rtl/vga_scan_checker.sv
module vga_scan_checker (
  input logic       clk,
  input logic       rst,
  input logic       hsync_n,
  input logic       dac_le,
  input logic       sram_oe_n,
  input logic       sram_we_n,
  input logic       addr_le,
  input logic       addr_b16,
  input logic [7:0] addr_bus,
  input logic       data_oe,
  input logic       pix_second_q
);
  p_sync_blank_r2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !dac_le);

  p_pixel_two_clk_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_le && pix_second_q) |-> ($stable(addr_bus) && $stable(addr_b16)));

  p_page_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_le && $rose(addr_b16)) |-> (addr_bus == 8'hFF));

  p_high_run_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_le && $past(dac_le) && addr_b16 && $past(addr_b16) && !pix_second_q)
      |-> (addr_bus == $past(addr_bus) + 8'd1));

  p_latch_closed_r6: assert property (@(posedge clk) disable iff (rst)
    dac_le |-> !addr_le);

  p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !data_oe);

  p_we_guarded_r9: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && data_oe && !addr_le));

  p_write_one_clk_r9: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> sram_we_n);
endmodule

bind vga_scanout vga_scan_checker u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .dac_le(dac_le),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .addr_le(addr_le),
  .addr_b16(addr_b16), .addr_bus(addr_bus), .data_oe(data_oe),
  .pix_second_q(pix_second_q)
);

// File: tb/test_vga_scanout.sv
module test_vga_scanout;
  localparam int HA = 640, HF = 16, HS = 96, HB = 48;
  localparam int VA = 8, VF = 1, VS = 1, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hsync_n, vsync_n, addr_le, addr_b16, dac_le;
  logic        sram_oe_n, sram_we_n, data_oe;
  logic [7:0]  addr_bus, data_out;
  logic [1:0]  addr_top;

  vga_scanout #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) i_vga_scanout (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .addr_bus(addr_bus), .addr_le(addr_le),
    .addr_b16(addr_b16), .addr_top(addr_top), .dac_le(dac_le),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .data_out(data_out),
    .data_oe(data_oe)
  );

  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_addr(input int row, input int pix);
    int base;
    base = row * 256;
    if (pix < 256) return base + pix;
    if (pix == 256) return 65536 + base + 255;
    return 65536 + base + (pix - 257);
  endfunction

  // ---------------- monitor: external latch + SRAM model + expected raster
  int nedge = 0;
  always @(posedge clk) begin
    if (rst) nedge = 0;
    else nedge = nedge + 1;
  end

  logic [7:0] latch_q = 8'h00;
  logic [7:0] mem [int];
  int cap [VA][320];
  int err_hs = 0, err_vs = 0, err_vid = 0, err_adr = 0, err_le = 0, err_bus = 0;
  int cur_h = -1, cur_v = -1;
  int wr_seen = 0, last_wa = 0, last_wd = 0, last_wh = 0, last_wv = 0;

  always @(negedge clk) begin
    int p, h, v, full, expa;
    bit act, ehs, evs;
    if (addr_le) latch_q = addr_bus;
    full = int'({addr_top, addr_b16, latch_q, addr_bus});
    if (nedge > 0) begin
      p = nedge - 1;
      h = p % HT;
      v = (p / HT) % VT;
      cur_h = h;
      cur_v = v;
      act = (h < HA) && (v < VA);
      ehs = !((h >= HA + HF) && (h < HA + HF + HS));
      evs = !((v >= VA + VF) && (v < VA + VF + VS));
      if (hsync_n !== ehs) err_hs++;
      if (vsync_n !== evs) err_vs++;
      if (dac_le !== act || sram_oe_n !== !act) err_vid++;
      if (act) begin
        expa = model_addr(v / 2, h / 2);
        if (full != expa) err_adr++;
        if (addr_le) err_le++;
        if (h % 2 == 0) cap[v][h/2] = full;
      end
      if (!sram_oe_n && data_oe) err_bus++;
      if (!sram_we_n) begin
        wr_seen++;
        last_wa = full;
        last_wd = int'(data_out);
        last_wh = h;
        last_wv = v;
        mem[full] = data_out;
        if (act || !sram_oe_n || !data_oe) err_bus++;
      end
    end
  end

  // ---------------- helpers
  task automatic wait_pos(input int n);
    while (nedge < n) @(negedge clk);
    #1;
  endtask

  task automatic issue_write(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_addr = a;
    wr_data = d;
    wr_valid = 1'b1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wr_seen < n) @(negedge clk);
    #1;
  endtask

  // ---------------- scenarios
  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(hsync_n === 1'b1 && vsync_n === 1'b1, "R1 syncs idle", {hsync_n, vsync_n}, 3);
    chk(dac_le === 1'b0 && sram_oe_n === 1'b1, "R1 video off", {dac_le, sram_oe_n}, 1);
    chk(sram_we_n === 1'b1 && data_oe === 1'b0 && addr_le === 1'b0, "R1 write idle",
        {sram_we_n, data_oe, addr_le}, 4);
    chk(wr_ready === 1'b1, "R1 ready", wr_ready, 1);
  endtask

  task automatic t_raster(input string tag);
    chk(err_hs == 0, {"R2 hsync ", tag}, err_hs, 0);
    chk(err_vs == 0, {"R3 vsync ", tag}, err_vs, 0);
    chk(err_vid == 0, {"R4 dac/oe ", tag}, err_vid, 0);
    chk(err_adr == 0, {"R5 address ", tag}, err_adr, 0);
    chk(err_le == 0, {"R6 latch closed ", tag}, err_le, 0);
    chk(err_bus == 0, {"R8 bus ", tag}, err_bus, 0);
  endtask

  task automatic t_page_points;
    chk(cap[2][0] == 256, "R5 row1 pix0", cap[2][0], 256);
    chk(cap[2][255] == 511, "R5 row1 pix255", cap[2][255], 511);
    chk(cap[2][256] == 66047, "R5 row1 pix256", cap[2][256], 66047);
    chk(cap[2][257] == 65792, "R5 row1 pix257", cap[2][257], 65792);
    chk(cap[2][319] == 65854, "R5 row1 pix319", cap[2][319], 65854);
    chk(cap[0][256] == 65791 && cap[0][319] == 65598, "R5 row0 tail",
        cap[0][319], 65598);
    chk(cap[6][300] == model_addr(3, 300), "R6 row3 from latch", cap[6][300],
        model_addr(3, 300));
    for (int pix = 0; pix < 320; pix++) begin
      if (cap[4][pix] != cap[5][pix]) begin
        chk(1'b0, "R7 doubled line", cap[5][pix], cap[4][pix]);
        break;
      end
    end
    chk(cap[5][100] == cap[4][100] && cap[4][100] != cap[3][100], "R7 row change",
        cap[4][100], model_addr(2, 100));
  endtask

  task automatic t_write_blank;
    int base;
    base = wr_seen;
    issue_write(19'h1_2345, 8'hA5);
    wait_writes(base + 1);
    chk(last_wa == 19'h1_2345, "R9 write address", last_wa, 19'h1_2345);
    chk(last_wd == 8'hA5, "R9 write data", last_wd, 8'hA5);
    chk(last_wh >= HA + 3 && last_wh <= HT - 6, "R9 strobe position", last_wh, HA + 3);
  endtask

  task automatic t_write_in_active;
    int base, vi;
    base = wr_seen;
    @(negedge clk); #1;
    while (!(cur_h == 10 && cur_v < VA)) begin @(negedge clk); #1; end
    vi = cur_v;
    wr_addr = 19'h0_0F0F;
    wr_data = 8'h3C;
    wr_valid = 1'b1;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    @(negedge clk); #1;
    chk(wr_ready === 1'b0, "R10 ready held", wr_ready, 0);
    chk(sram_we_n === 1'b1, "R10 no strobe in active", sram_we_n, 1);
    wait_writes(base + 1);
    chk(last_wv == vi && last_wh == HA + 3, "R10 deferred slot", last_wh, HA + 3);
    chk(last_wa == 19'h0_0F0F && last_wd == 8'h3C, "R10 deferred data", last_wd, 8'h3C);
  endtask

  task automatic t_back_to_back;
    int base;
    base = wr_seen;
    issue_write(19'h6_ABCD, 8'h11);
    issue_write(19'h2_0001, 8'h22);
    wait_writes(base + 2);
    chk(last_wa == 19'h2_0001, "R11 order", last_wa, 19'h2_0001);
    chk(mem.exists(19'h6_ABCD) && mem[19'h6_ABCD] == 8'h11, "R11 first kept",
        mem.exists(19'h6_ABCD) ? int'(mem[19'h6_ABCD]) : -1, 8'h11);
    chk(mem[19'h2_0001] == 8'h22, "R11 second", int'(mem[19'h2_0001]), 8'h22);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    t_reset();
    @(posedge clk); #1;
    rst = 1'b0;
    wait_pos(FRAME + 20);
    t_raster("first frame");
    t_page_points();
    t_write_blank();
    t_write_in_active();
    t_back_to_back();
    wait_pos(nedge + FRAME + 20);
    t_raster("after writes R11");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end
endmodule